// File: doc/BRIEF.md
# Mode-Selectable Latched I/O Port

This block is an 8-bit port for a small processor system. It can serve as a data latch, as a gated buffer, or as an input port that raises an interrupt. A mode input chooses what loads the data register. In output mode the device-select condition loads it. In input mode a strobe loads it.

The mode input also chooses what drives the output-enable flag. In output mode the flag is always on. In input mode it follows the select condition. A separate output-enable flag stands in for a high-impedance pad, and the data output reads zero whenever that flag is off.

The data register behaves like a level-sensitive latch. While its load control is high it passes the input straight through, and it keeps the last value when the load control goes low. A service request flag is set by a falling strobe edge and cleared when the device is selected. It drives an active-low interrupt line.

All inputs pass through a two-stage synchronizer on the system clock. The block behaves identically in both modes apart from the choice of load source and output enable.

Top module: `sel_io_port`

## Requirements
- R1: Every input reaches the outputs through a two-stage synchronizer. A change applied before clock edge k shows on the combinational outputs after edge k+1 and not after edge k.
- R2: The device counts as selected only when `cs_lo_n` is 0 and `cs_hi` is 1. While it is selected, `int_n` is 0.
- R3: With `out_mode` = 1, `dout_oe` is 1 on every cycle, and the device-select condition is the latch load control.
- R4: With `out_mode` = 0, `dout_oe` equals the select condition, and `strobe` is the latch load control.
- R5: While the load control is 1, `dout` shows the synchronized `din` (transparent). When the load control drops, the register keeps the last value it passed, and later changes to `din` have no effect on `dout`.
- R6: While the synchronized `clear_n` is 0 and the load control is 0, the latch is cleared to all zeros at the next clock edge. While the load control is 1, the clear has no effect and the latch stays transparent.
- R7: A 1-to-0 transition of the synchronized `strobe` sets the service request one clock edge later, which drives `int_n` to 0. Each falling edge sets it once, and the request stays set until it is cleared.
- R8: The request is cleared at the next clock edge while the device is selected or `clear_n` is 0. Either of these wins over a falling strobe in the same cycle.
- R9: While `dout_oe` is 0, `dout` reads all zeros.
- R10: After `rst_n` is released, `dout` is 0, `dout_oe` is 0 and `int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| din | input | DATA_W | Data input |
| cs_lo_n | input | 1 | Select input, active low |
| cs_hi | input | 1 | Select input, active high |
| out_mode | input | 1 | 1 = output mode, 0 = input mode |
| strobe | input | 1 | Latch load in input mode; its falling edge sets the request |
| clear_n | input | 1 | Clear of latch and request, active low |
| dout | output | DATA_W | Data output, zero while disabled |
| dout_oe | output | 1 | Output enable, stands in for tri-state |
| int_n | output | 1 | Interrupt request, active low |

## Verification
The assertions check several relations on every cycle:
- output mode forces the enable;
- a disabled port reads zero;
- selection pulls the interrupt low;
- a falling strobe sets the request unless selection or clear overrides it;
- the register either holds, loads, or clears, as its controls dictate.

Some behaviour only the bench scenarios can show. These are the two-cycle input latency, and the transparency of the latch toward the live input. They also include the override of a clear by an active load, and the fact that a single strobe pulse raises one persistent request. The bench's reference model reproduces these from the inputs alone.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef struct packed {
    logic cs_lo_n;
    logic cs_hi;
    logic out_mode;
    logic strobe;
    logic clear_n;
  } sio_ctl_t;

  localparam int unsigned CTL_W = $bits(sio_ctl_t);

  localparam sio_ctl_t CTL_IDLE = '{cs_lo_n: 1'b1, cs_hi: 1'b0, out_mode: 1'b0,
                                    strobe: 1'b0, clear_n: 1'b1};

  function automatic logic is_selected(input logic lo_n, input logic hi);
    return (!lo_n) && hi;
  endfunction

  function automatic logic load_ctl(input logic out_mode, input logic selected,
                                    input logic stb);
    return out_mode ? selected : stb;
  endfunction

  function automatic logic out_enable(input logic out_mode, input logic selected);
    return out_mode | selected;
  endfunction

  function automatic logic req_next(input logic cur, input logic fall,
                                    input logic selected, input logic clr_act);
    if (selected || clr_act) return 1'b0;
    if (fall) return 1'b1;
    return cur;
  endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/sio_datalatch.sv
module sio_datalatch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clr_act,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_held,
  output logic [W-1:0] q_view
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_held <= '0;
    else if (load)    q_held <= d;
    else if (clr_act) q_held <= '0;
  end

  assign q_view = load ? d : q_held;
endmodule

// File: rtl/sio_srq.sv
module sio_srq (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_s,
  input  logic selected,
  input  logic clr_act,
  output logic fall,
  output logic req
);
  import sio_pkg::*;

  logic stb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_prev <= 1'b0;
    else        stb_prev <= stb_s;
  end

  assign fall = stb_prev & ~stb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_next(req, fall, selected, clr_act);
  end
endmodule

// File: rtl/sel_io_port.sv
module sel_io_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic              out_mode,
  input  logic              strobe,
  input  logic              clear_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              int_n
);
  import sio_pkg::*;

  localparam int unsigned IN_W = DATA_W + CTL_W;
  localparam logic [IN_W-1:0] IN_RST = {{DATA_W{1'b0}}, CTL_IDLE};

  logic [IN_W-1:0]   raw_in;
  logic [IN_W-1:0]   smp_in;
  sio_ctl_t          ctl_s;
  logic [DATA_W-1:0] din_s;

  logic              selected;
  logic              load;
  logic              clr_act;
  logic              stb_fall;
  logic              req_q;
  logic [DATA_W-1:0] latch_q;
  logic [DATA_W-1:0] latch_view;

  assign raw_in = {din, cs_lo_n, cs_hi, out_mode, strobe, clear_n};

  sio_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (smp_in)
  );

  assign din_s = smp_in[IN_W-1:CTL_W];
  assign ctl_s = sio_ctl_t'(smp_in[CTL_W-1:0]);

  assign selected = is_selected(ctl_s.cs_lo_n, ctl_s.cs_hi);
  assign load     = load_ctl(ctl_s.out_mode, selected, ctl_s.strobe);
  assign clr_act  = ~ctl_s.clear_n;

  sio_datalatch #(.W(DATA_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .clr_act (clr_act),
    .d       (din_s),
    .q_held  (latch_q),
    .q_view  (latch_view)
  );

  sio_srq u_srq (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_s    (ctl_s.strobe),
    .selected (selected),
    .clr_act  (clr_act),
    .fall     (stb_fall),
    .req      (req_q)
  );

  assign dout_oe = out_enable(ctl_s.out_mode, selected);

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_gate
      assign dout[b] = latch_view[b] & dout_oe;
    end
  endgenerate

  assign int_n = ~(req_q | selected);
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              selected,
  input logic              load,
  input logic              mode_s,
  input logic              clr_act,
  input logic              stb_fall,
  input logic              req_q,
  input logic [DATA_W-1:0] latch_q,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe,
  input logic              int_n
);
  AST_OUT_MODE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_s |-> dout_oe); // R3
  AST_IN_MODE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |-> (dout_oe == selected)); // R4
  AST_SELECT_INTERRUPTS: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> !int_n); // R2
  AST_DISABLED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == '0)); // R9
  AST_FALL_SETS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && !selected && !clr_act) |=> req_q); // R7
  AST_SELECT_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (selected || clr_act) |=> !req_q); // R8
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr_act) |=> $stable(latch_q)); // R5
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && clr_act) |=> (latch_q == '0)); // R6
endmodule

bind sel_io_port sio_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .selected (selected),
  .load     (load),
  .mode_s   (ctl_s.out_mode),
  .clr_act  (clr_act),
  .stb_fall (stb_fall),
  .req_q    (req_q),
  .latch_q  (latch_q),
  .dout     (dout),
  .dout_oe  (dout_oe),
  .int_n    (int_n)
);

// File: tb/test_sel_io_port.sv
module test_sel_io_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] din = '0;
  logic         cs_lo_n = 1'b1, cs_hi = 1'b0, out_mode = 1'b0, strobe = 1'b0, clear_n = 1'b1;
  logic [W-1:0] dout;
  logic         dout_oe, int_n;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sel_io_port #(.DATA_W(W)) i_sel_io_port (
    .clk(clk), .rst_n(rst_n), .din(din), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
    .out_mode(out_mode), .strobe(strobe), .clear_n(clear_n),
    .dout(dout), .dout_oe(dout_oe), .int_n(int_n));

  // Behavioural reference: inputs seen two edges late, latch and request
  logic [W-1:0] p_din, s_din, m_latch;
  logic p_lo, p_hi, p_md, p_stb, p_clr;
  logic s_lo, s_hi, s_md, s_stb, s_clr;
  logic m_prev, m_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_din = '0; s_din = '0; m_latch = '0;
      p_lo = 1; p_hi = 0; p_md = 0; p_stb = 0; p_clr = 1;
      s_lo = 1; s_hi = 0; s_md = 0; s_stb = 0; s_clr = 1;
      m_prev = 0; m_req = 0;
    end else begin
      bit sel_now, ld_now;
      sel_now = (s_lo == 0) && (s_hi == 1);
      ld_now  = s_md ? sel_now : s_stb;
      if (ld_now) m_latch = s_din;
      else if (!s_clr) m_latch = '0;
      if (sel_now || !s_clr) m_req = 0;
      else if (m_prev && !s_stb) m_req = 1;
      m_prev = s_stb;
      {s_din, s_lo, s_hi, s_md, s_stb, s_clr} = {p_din, p_lo, p_hi, p_md, p_stb, p_clr};
      {p_din, p_lo, p_hi, p_md, p_stb, p_clr} = {din, cs_lo_n, cs_hi, out_mode, strobe, clear_n};
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_sel, e_ld, e_oe;
      logic [W-1:0] e_out;
      e_sel = (s_lo == 0) && (s_hi == 1);
      e_ld  = s_md ? e_sel : s_stb;
      e_oe  = s_md | e_sel;
      e_out = !e_oe ? '0 : (e_ld ? s_din : m_latch);
      check(e_oe ? "R5 dout" : "R9 dout", dout, e_out);
      check(s_md ? "R3 oe" : "R4 oe", {7'b0, dout_oe}, {7'b0, e_oe});
      check("R7 int_n", {7'b0, int_n}, {7'b0, !(m_req || e_sel)});
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    check("R10 dout", dout, '0);
    check("R10 oe", {7'b0, dout_oe}, 8'h00);
    check("R10 int_n", {7'b0, int_n}, 8'h01);

    // Output mode, latency and load by select
    out_mode = 1; din = 8'hA5; cs_lo_n = 0; cs_hi = 1;
    wait_n(1);
    check("R1 before", dout, 8'h00);
    wait_n(1);
    check("R1 after", dout, 8'hA5);
    check("R3 oe", {7'b0, dout_oe}, 8'h01);
    cs_lo_n = 1; wait_n(3);
    din = 8'h3C; wait_n(3);
    check("R5 hold", dout, 8'hA5);
    check("R3 oe desel", {7'b0, dout_oe}, 8'h01);

    // Select decode
    cs_lo_n = 0; cs_hi = 0; wait_n(3);
    check("R2 lo only", {7'b0, int_n}, 8'h01);
    cs_lo_n = 1; cs_hi = 1; wait_n(3);
    check("R2 hi only", {7'b0, int_n}, 8'h01);
    cs_lo_n = 0; wait_n(3);
    check("R2 selected", {7'b0, int_n}, 8'h00);
    cs_lo_n = 1; wait_n(3);

    // Input mode
    out_mode = 0; wait_n(3);
    check("R4 oe off", {7'b0, dout_oe}, 8'h00);
    check("R9 zero", dout, 8'h00);
    strobe = 1; din = 8'h77; wait_n(3);
    check("R9 zero loading", dout, 8'h00);
    cs_lo_n = 0; wait_n(3);
    check("R5 transparent", dout, 8'h77);
    din = 8'h78; wait_n(3);
    check("R5 follows", dout, 8'h78);
    strobe = 0; wait_n(3);
    din = 8'h11; wait_n(3);
    check("R5 captured", dout, 8'h78);
    cs_lo_n = 1; wait_n(3);
    check("R8 select beats fall", {7'b0, int_n}, 8'h01);

    // Strobe pulse raises one request
    strobe = 1; wait_n(3);
    strobe = 0; wait_n(2);
    check("R7 not yet", {7'b0, int_n}, 8'h01);
    wait_n(1);
    check("R7 set", {7'b0, int_n}, 8'h00);
    wait_n(5);
    check("R7 stays", {7'b0, int_n}, 8'h00);
    cs_lo_n = 0; wait_n(3);
    cs_lo_n = 1; wait_n(3);
    check("R8 select clears", {7'b0, int_n}, 8'h01);

    // Clear behaviour
    cs_lo_n = 0; wait_n(3);
    check("R6 before clear", dout, 8'h11);
    clear_n = 0; wait_n(1);
    clear_n = 1; wait_n(4);
    check("R6 cleared", dout, 8'h00);
    strobe = 1; din = 8'h5A; clear_n = 0; wait_n(5);
    check("R6 load overrides", dout, 8'h5A);
    clear_n = 1; strobe = 0; wait_n(4);
    check("R6 kept", dout, 8'h5A);

    // Clear and falling strobe in the same cycle
    cs_lo_n = 1; strobe = 1; wait_n(3);
    strobe = 0; clear_n = 0; wait_n(4);
    clear_n = 1; wait_n(3);
    check("R8 clear beats fall", {7'b0, int_n}, 8'h01);

    wait_n(2);
    finish_run();
  end
endmodule